// File: doc/BRIEF.md
# DDR SDRAM Low-Power Command Monitor

This block observes the control pins of a DDR SDRAM bus (clock enable, chip select, row strobe, column strobe and write enable) on every rising clock edge. It decodes the refresh and power-mode commands from two CKE samples, the one from the previous cycle and the current one, together with the command pins. It follows the device through three states: `IDLE`, `SELF` (self-refresh) and `PDOWN` (power-down). Read, write and activate commands matter only where the refresh and exit timing rules constrain them. Address pins and data paths are not observed.

Each rule violation sets its own sticky error output, and only reset clears it. The state machine has these transitions. `IDLE -> SELF` on self-refresh entry. `IDLE -> PDOWN` on power-down entry, or on any other CKE fall. `SELF -> IDLE` and `PDOWN -> IDLE` on any CKE rise, which is the exit. All other cases hold the state. The surrounding model provides a bank-idle flag. Exit and refresh latencies are parameters given in clock cycles.

Top module: `ddr_lp_monitor`

## Requirements
- R1: Commands are decoded with active-low pins as follows. With CKE high in both samples, `cs_n=0 ras_n=0 cas_n=0 we_n=1` is an auto-refresh. With CKE falling high to low, that same pattern is a self-refresh entry (`IDLE -> SELF`). A CKE fall with deselect (`cs_n=1`) or NOP (`cs_n=0`, the other three high) is a power-down entry (`IDLE -> PDOWN`). Any CKE rise leaves `SELF` or `PDOWN` for `IDLE`.
- R2: After reset, `state_o` is 0 (`IDLE`) and all error outputs are 0. The previous CKE sample is taken as high.
- R3: `err_bank` sets when an auto-refresh or a self-refresh entry is decoded while `banks_idle` is 0.
- R4: `err_cke_hold` sets when CKE changes level in two consecutive cycles.
- R5: `err_illegal` sets in either of two cases. One is a CKE fall whose pins are neither the refresh pattern nor deselect/NOP; that fall still enters `PDOWN`. The other is a CKE rise whose pins are neither deselect nor NOP; that rise still returns to `IDLE`.
- R6: `err_rfc` sets when an activate (`0,0,1,1`) or a mode-register set (`0,0,0,0`) comes fewer than `T_RFC` cycles after an auto-refresh.
- R7: `err_xsnr` sets when a command other than read comes fewer than `T_XSNR` cycles after a self-refresh exit. Such a command is anything other than deselect or NOP, with CKE high in both samples. A command exactly `T_XSNR` cycles later is legal.
- R8: `err_xsrd` sets when a read (`0,1,0,1`) comes fewer than `T_XSRD` cycles after a self-refresh exit. A read in that window does not set `err_xsnr`.
- R9: Error outputs are sticky until reset. Pin activity while CKE is low in both samples has no effect on state or errors.
- R10: `state_o` (0 `IDLE`, 1 `SELF`, 2 `PDOWN`) and the error outputs change on the clock edge that samples the command, and are visible in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cke | input | 1 | Clock enable as seen on the bus |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| banks_idle | input | 1 | 1 when every bank is precharged |
| state_o | output | 2 | Tracked device state |
| err_bank | output | 1 | Sticky: refresh with an open bank |
| err_illegal | output | 1 | Sticky: bad pins on a CKE edge |
| err_cke_hold | output | 1 | Sticky: CKE held under one cycle |
| err_rfc | output | 1 | Sticky: activate or mode set too soon after refresh |
| err_xsnr | output | 1 | Sticky: non-read too soon after self-refresh exit |
| err_xsrd | output | 1 | Sticky: read too soon after self-refresh exit |

## Verification
The properties assume that CKE and the command pins are settled at each rising edge, and that `banks_idle` is valid in the same cycle as the command. They also assume that the tracked state is `IDLE` whenever CKE was high in the previous sample. The stimulus changes every input only at the falling edge. It starts each run with CKE high after reset, and it raises or lowers CKE only through whole-cycle steps, so the decoder always sees a defined pair of samples. Each error class is first approached with legal timing at the window edge and only afterwards violated, so a single sticky bit is known to belong to one cause.

// File: rtl/ddr_lp_pkg.sv
package ddr_lp_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SELF  = 2'd1,
        ST_PDOWN = 2'd2
    } lp_state_e;

    typedef enum logic [3:0] {
        CMD_NONE,      // deselect or NOP, CKE high both samples
        CMD_LOW,       // CKE low both samples
        CMD_REF,
        CMD_SRE,
        CMD_PDE,
        CMD_EXIT,
        CMD_ACT,
        CMD_MRS,
        CMD_READ,
        CMD_OTHER,
        CMD_BAD_FALL,
        CMD_BAD_RISE
    } lp_cmd_e;

endpackage

// File: rtl/ddr_lp_decode.sv
module ddr_lp_decode
    import ddr_lp_pkg::*;
(
    input  logic    cke_prev,
    input  logic    cke,
    input  logic    cs_n,
    input  logic    ras_n,
    input  logic    cas_n,
    input  logic    we_n,
    output lp_cmd_e cmd
);
    logic idle_pins;
    logic ref_pins;

    assign idle_pins = cs_n | (ras_n & cas_n & we_n);
    assign ref_pins  = ~cs_n & ~ras_n & ~cas_n & we_n;

    always_comb begin
        cmd = CMD_NONE;
        unique case ({cke_prev, cke})
            2'b11: begin
                if (idle_pins)                      cmd = CMD_NONE;
                else if (ref_pins)                  cmd = CMD_REF;
                else if (!ras_n && cas_n && we_n)   cmd = CMD_ACT;
                else if (!ras_n && !cas_n && !we_n) cmd = CMD_MRS;
                else if (ras_n && !cas_n && we_n)   cmd = CMD_READ;
                else                                cmd = CMD_OTHER;
            end
            2'b10: begin
                if (ref_pins)       cmd = CMD_SRE;
                else if (idle_pins) cmd = CMD_PDE;
                else                cmd = CMD_BAD_FALL;
            end
            2'b01:   cmd = idle_pins ? CMD_EXIT : CMD_BAD_RISE;
            default: cmd = CMD_LOW;
        endcase
    end
endmodule

// File: rtl/ddr_lp_window.sv
module ddr_lp_window #(
    parameter int LIMIT = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic early
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] CMAX = CW'(LIMIT);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n)          cnt_q <= CMAX;
        else if (start)      cnt_q <= CW'(1);
        else if (cnt_q < CMAX) cnt_q <= cnt_q + CW'(1);
    end

    assign early = (cnt_q < CMAX);
endmodule

// File: rtl/ddr_lp_monitor.sv
module ddr_lp_monitor
    import ddr_lp_pkg::*;
#(
    parameter int T_RFC  = 9,
    parameter int T_XSNR = 10,
    parameter int T_XSRD = 200
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cke,
    input  logic       cs_n,
    input  logic       ras_n,
    input  logic       cas_n,
    input  logic       we_n,
    input  logic       banks_idle,
    output logic [1:0] state_o,
    output logic       err_bank,
    output logic       err_illegal,
    output logic       err_cke_hold,
    output logic       err_rfc,
    output logic       err_xsnr,
    output logic       err_xsrd
);
    localparam int NWIN = 3;
    localparam int WIN_LIMIT [NWIN] = '{T_RFC, T_XSNR, T_XSRD};

    lp_state_e st_q, st_d;
    lp_cmd_e   cmd;
    logic      cke_q, chg_q, changed;
    logic      srx_start;
    logic [NWIN-1:0] win_start, win_early;

    ddr_lp_decode u_dec (
        .cke_prev (cke_q),
        .cke      (cke),
        .cs_n     (cs_n),
        .ras_n    (ras_n),
        .cas_n    (cas_n),
        .we_n     (we_n),
        .cmd      (cmd)
    );

    assign changed   = cke ^ cke_q;
    assign srx_start = (st_q == ST_SELF) && (cmd == CMD_EXIT || cmd == CMD_BAD_RISE);
    assign win_start = {srx_start, srx_start, cmd == CMD_REF};

    for (genvar gi = 0; gi < NWIN; gi++) begin : g_win
        ddr_lp_window #(.LIMIT(WIN_LIMIT[gi])) u_win (
            .clk   (clk),
            .rst_n (rst_n),
            .start (win_start[gi]),
            .early (win_early[gi])
        );
    end

    // next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: begin
                if (cmd == CMD_SRE) st_d = ST_SELF;
                else if (cmd == CMD_PDE || cmd == CMD_BAD_FALL) st_d = ST_PDOWN;
            end
            ST_SELF, ST_PDOWN: begin
                if (cmd == CMD_EXIT || cmd == CMD_BAD_RISE) st_d = ST_IDLE;
            end
            default: st_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            cke_q <= 1'b1;
            chg_q <= 1'b0;
        end else begin
            st_q  <= st_d;
            cke_q <= cke;
            chg_q <= changed;
        end
    end

    // sticky error outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_bank     <= 1'b0;
            err_illegal  <= 1'b0;
            err_cke_hold <= 1'b0;
            err_rfc      <= 1'b0;
            err_xsnr     <= 1'b0;
            err_xsrd     <= 1'b0;
        end else begin
            if ((cmd == CMD_REF || cmd == CMD_SRE) && !banks_idle)
                err_bank <= 1'b1;
            if (cmd == CMD_BAD_FALL || cmd == CMD_BAD_RISE)
                err_illegal <= 1'b1;
            if (changed && chg_q)
                err_cke_hold <= 1'b1;
            if ((cmd == CMD_ACT || cmd == CMD_MRS) && win_early[0])
                err_rfc <= 1'b1;
            if ((cmd == CMD_REF || cmd == CMD_ACT || cmd == CMD_MRS || cmd == CMD_OTHER)
                && win_early[1])
                err_xsnr <= 1'b1;
            if (cmd == CMD_READ && win_early[2])
                err_xsrd <= 1'b1;
        end
    end

    assign state_o = st_q;
endmodule

// File: rtl/ddr_lp_monitor_chk.sv
module ddr_lp_monitor_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cke,
    input logic       cs_n,
    input logic       ras_n,
    input logic       cas_n,
    input logic       we_n,
    input logic       banks_idle,
    input logic [1:0] state_o,
    input logic       err_bank,
    input logic       err_illegal,
    input logic       err_cke_hold,
    input logic       err_rfc,
    input logic       err_xsnr,
    input logic       err_xsrd
);
    logic [5:0] errs;
    assign errs = {err_bank, err_illegal, err_cke_hold, err_rfc, err_xsnr, err_xsrd};

    p_state_code_r1: assert property (@(posedge clk) disable iff (!rst_n)
        state_o != 2'd3);

    p_low_needs_cke_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o != 2'd0 && cke) |=> state_o == 2'd0);

    p_bank_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cke && !cs_n && !ras_n && !cas_n && we_n && !banks_idle) |=> err_bank);

    p_bad_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o != 2'd0 && cke && !cs_n && !(ras_n && cas_n && we_n)) |=> err_illegal);

    p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (errs != 6'd0) |=> ((errs & $past(errs)) == $past(errs)));

    p_hold_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o != 2'd0 && !cke) |=> $stable(state_o));
endmodule

bind ddr_lp_monitor ddr_lp_monitor_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cke          (cke),
    .cs_n         (cs_n),
    .ras_n        (ras_n),
    .cas_n        (cas_n),
    .we_n         (we_n),
    .banks_idle   (banks_idle),
    .state_o      (state_o),
    .err_bank     (err_bank),
    .err_illegal  (err_illegal),
    .err_cke_hold (err_cke_hold),
    .err_rfc      (err_rfc),
    .err_xsnr     (err_xsnr),
    .err_xsrd     (err_xsrd)
);

// File: tb/test_ddr_lp_monitor.sv
`timescale 1ns/1ps
module test_ddr_lp_monitor;
    localparam int T_RFC  = 9;
    localparam int T_XSNR = 10;
    localparam int T_XSRD = 200;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cke = 1'b1, cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic banks_idle = 1'b1;
    logic [1:0] state_o;
    logic err_bank, err_illegal, err_cke_hold, err_rfc, err_xsnr, err_xsrd;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit done = 0;

    // reference model state
    int  m_state;
    bit  m_cke, m_chg;
    int  since_ref, since_srx;
    bit  m_bank, m_ill, m_hold, m_rfc, m_snr, m_srd;

    always #2.5 clk = ~clk;

    ddr_lp_monitor #(.T_RFC(T_RFC), .T_XSNR(T_XSNR), .T_XSRD(T_XSRD)) i_ddr_lp_monitor (
        .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
        .cas_n(cas_n), .we_n(we_n), .banks_idle(banks_idle), .state_o(state_o),
        .err_bank(err_bank), .err_illegal(err_illegal), .err_cke_hold(err_cke_hold),
        .err_rfc(err_rfc), .err_xsnr(err_xsnr), .err_xsrd(err_xsrd)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    task automatic model_reset();
        m_state = 0; m_cke = 1; m_chg = 0;
        since_ref = 1000000; since_srx = 1000000;
        {m_bank, m_ill, m_hold, m_rfc, m_snr, m_srd} = '0;
    endtask

    task automatic model_step(input bit k, input bit cs, input bit ras,
                              input bit cas, input bit we, input bit idle);
        bit quiet, refp, isread, ischg;
        quiet  = cs || (ras && cas && we);
        refp   = !cs && !ras && !cas && we;
        isread = !cs && ras && !cas && we;
        ischg  = (k != m_cke);
        if (since_ref < 1000000) since_ref++;
        if (since_srx < 1000000) since_srx++;
        if (ischg && m_chg) m_hold = 1;
        if (m_cke && k) begin
            if (refp && !idle) m_bank = 1;
            if (!quiet) begin
                if (isread && since_srx < T_XSRD) m_srd = 1;
                if (!isread && since_srx < T_XSNR) m_snr = 1;
                if (!ras && we && (cas || !cas) && !(refp) && since_ref < T_RFC
                    && (cas || !we)) m_rfc = 1;
                if (!ras && !cas && !we && since_ref < T_RFC) m_rfc = 1;
            end
            if (refp) since_ref = 0;
        end else if (m_cke && !k) begin
            if (refp) begin
                if (!idle) m_bank = 1;
                m_state = 1;
            end else begin
                if (!quiet) m_ill = 1;
                m_state = 2;
            end
        end else if (!m_cke && k) begin
            if (!quiet) m_ill = 1;
            if (m_state == 1) since_srx = 0;
            m_state = 0;
        end
        m_chg = ischg;
        m_cke = k;
    endtask

    task automatic compare_all();
        chk("R1 R10 state", state_o, m_state);
        chk("R3 err_bank", err_bank, m_bank);
        chk("R5 err_illegal", err_illegal, m_ill);
        chk("R4 err_cke_hold", err_cke_hold, m_hold);
        chk("R6 err_rfc", err_rfc, m_rfc);
        chk("R7 err_xsnr", err_xsnr, m_snr);
        chk("R8 err_xsrd", err_xsrd, m_srd);
    endtask

    task automatic step(input bit k, input bit cs, input bit ras,
                        input bit cas, input bit we, input bit idle);
        cke = k; cs_n = cs; ras_n = ras; cas_n = cas; we_n = we; banks_idle = idle;
        @(posedge clk);
        model_step(k, cs, ras, cas, we, idle);
        @(negedge clk);
        compare_all();
    endtask

    task automatic nops(input int n, input bit k);
        for (int i = 0; i < n; i++) step(k, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1);
    endtask

    task automatic do_reset();
        rst_n = 0;
        cke = 1; cs_n = 1; ras_n = 1; cas_n = 1; we_n = 1; banks_idle = 1;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        model_reset();
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            done = 1;
            failures++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 100000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        model_reset();
        do_reset();
        // R2: reset state
        chk("R2 state after reset", state_o, 0);
        chk("R2 errors after reset",
            {err_bank, err_illegal, err_cke_hold, err_rfc, err_xsnr, err_xsrd}, 0);
        nops(3, 1'b1);

        // legal auto-refresh, activate exactly T_RFC later, then mode set (R6)
        step(1, 0, 0, 0, 1, 1);
        nops(T_RFC - 1, 1'b1);
        step(1, 0, 0, 1, 1, 1);
        step(1, 0, 0, 0, 0, 1);
        chk("R6 activate at T_RFC legal", err_rfc, 0);

        // power-down entry with deselect, low hold with junk pins ignored, exit (R1, R9)
        step(0, 1, 1, 1, 1, 1);
        chk("R1 power-down entered", state_o, 2);
        step(0, 0, 0, 0, 0, 1);
        step(0, 0, 1, 0, 1, 1);
        chk("R9 pins ignored while CKE low", state_o, 2);
        chk("R9 no error while CKE low",
            {err_bank, err_illegal, err_cke_hold, err_rfc, err_xsnr, err_xsrd}, 0);
        step(1, 1, 0, 0, 0, 1);
        chk("R1 power-down exit", state_o, 0);
        nops(2, 1'b1);

        // self-refresh entry, exit, non-read at T_XSNR, read at T_XSRD (R1, R7, R8)
        step(0, 0, 0, 0, 1, 1);
        chk("R1 self-refresh entered", state_o, 1);
        nops(4, 1'b0);
        step(1, 0, 1, 1, 1, 1);
        chk("R1 self-refresh exit", state_o, 0);
        nops(T_XSNR - 1, 1'b1);
        step(1, 0, 0, 1, 0, 1);
        chk("R7 non-read at T_XSNR legal", err_xsnr, 0);
        nops(T_XSRD - T_XSNR - 1, 1'b1);
        step(1, 0, 1, 0, 1, 1);
        chk("R8 read at T_XSRD legal", err_xsrd, 0);
        nops(2, 1'b1);

        // early read then early write after self-refresh exit (R8, R7)
        step(0, 0, 0, 0, 1, 1);
        nops(3, 1'b0);
        step(1, 1, 1, 1, 1, 1);
        nops(4, 1'b1);
        step(1, 0, 1, 0, 1, 1);
        chk("R8 early read flagged", err_xsrd, 1);
        chk("R8 early read not counted as non-read", err_xsnr, 0);
        step(1, 0, 1, 0, 0, 1);
        chk("R7 early write flagged", err_xsnr, 1);
        nops(T_XSRD, 1'b1);

        // activate too soon after refresh (R6)
        step(1, 0, 0, 0, 1, 1);
        step(1, 1, 1, 1, 1, 1);
        step(1, 0, 0, 1, 1, 1);
        chk("R6 early activate flagged", err_rfc, 1);
        nops(T_RFC, 1'b1);

        // refresh with an open bank (R3)
        step(1, 0, 0, 0, 1, 0);
        chk("R3 refresh with open bank", err_bank, 1);
        nops(T_RFC, 1'b1);

        // CKE fall with activate pins: illegal, still power-down (R5)
        step(0, 0, 0, 1, 1, 1);
        chk("R5 bad fall flagged", err_illegal, 1);
        chk("R5 bad fall enters power-down", state_o, 2);
        nops(2, 1'b0);
        step(1, 1, 1, 1, 1, 1);
        // immediate fall after rise: CKE held under one cycle (R4)
        step(0, 1, 1, 1, 1, 1);
        chk("R4 short CKE level flagged", err_cke_hold, 1);
        nops(3, 1'b0);
        step(1, 1, 1, 1, 1, 1);
        nops(3, 1'b1);
        chk("R9 errors remain set",
            {err_bank, err_illegal, err_cke_hold, err_rfc, err_xsnr, err_xsrd}, 6'h3f);

        // reset clears everything (R2)
        do_reset();
        chk("R2 errors cleared by reset",
            {err_bank, err_illegal, err_cke_hold, err_rfc, err_xsnr, err_xsrd}, 0);
        chk("R2 state after second reset", state_o, 0);
        nops(2, 1'b1);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule